// File: doc/BRIEF.md
# Prioritized Timing Reference Selector

This block watches a set of 8 kHz reference clocks, each one recovered from an incoming E1 line, and chooses one of them as the active timing source for a downstream frequency-steering loop. Each reference passes through a two-flop synchronizer and then an activity monitor. The monitor measures the spacing of rising edges in system-clock cycles. It declares an input lost when edges stop arriving, and it declares the input healthy again only after a run of correctly spaced periods.

A priority table of slots picks the winner. Slot 0 is the most preferred. Each slot names an input index, and a per-input enable mask can exclude inputs. The selector always tracks the most preferred enabled healthy input. It falls back down the table when that input fails, and it returns to it once the input has requalified. A free-running control drops every reference. The outputs are the chosen index, a valid flag, a one-cycle pulse on every change of selection (so the downstream loop can clear its phase accumulator), and the synchronized level of the chosen reference.

The per-input monitor has three states. In `MON_LOST`, the first edge moves it to `MON_QUAL`. In `MON_QUAL`, an in-window period advances the run count, an out-of-window period clears it, the last required period moves it to `MON_GOOD`, and a timeout returns it to `MON_LOST`. In `MON_GOOD`, a timeout returns it to `MON_LOST`. The selector also has three states. `SEL_FREE` is entered while free-running is requested. `SEL_SEARCH` is entered when no candidate exists. `SEL_TRACK` is entered when a candidate exists. Each clock, the selector re-evaluates the transition out of its current state.

Top module: `tsel_ref_selector`

## Requirements
- R1: After a synchronous reset, ref_valid, switch_event and ref_out are 0, ref_sel is 0, and every input counts as unhealthy.
- R2: An input becomes healthy after its first synchronized rising edge is followed by QUAL_PERIODS consecutive edge-to-edge periods within NOM_PERIOD ± TOL_CYCLES system cycles.
- R3: An input whose periods all lie outside that window never becomes a selection candidate.
- R4: A healthy input whose synchronized edges stop for LOSS_LIMIT system cycles becomes unhealthy.
- R5: Selection goes to the input named by the lowest-numbered slot whose entry is an enabled, healthy input. Slot k occupies bits [k*IDX_W +: IDX_W] of prio_slots. Entries of N_REF or more never match.
- R6: When the selected input fails, selection moves to the next qualifying slot. When a more preferred input requalifies, selection returns to it.
- R7: An input whose ref_en bit is 0 is never selected, even when it is healthy.
- R8: While free_run is 1, ref_valid is 0 from the next cycle on.
- R9: While no input qualifies, ref_valid is 0 and ref_sel and ref_out are 0.
- R10: switch_event is high for exactly one cycle whenever the selection takes a new value, including the change from invalid to valid. It is never high while ref_valid is 0.
- R11: While valid, ref_out equals the selected ref_in bit delayed by two system clocks.
- R12: A change in health, enable mask, priority table or free_run is reflected in ref_sel and ref_valid one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 16.384 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | N_REF | Asynchronous 8 kHz references, one per line |
| ref_en | input | N_REF | Per-input enable mask |
| prio_slots | input | N_REF*IDX_W | Priority table; slot 0 in the low bits is most preferred |
| free_run | input | 1 | Ignore all references |
| ref_sel | output | IDX_W | Index of the selected input |
| ref_valid | output | 1 | A reference is selected |
| switch_event | output | 1 | One-cycle pulse on a change of selection |
| ref_out | output | 1 | Synchronized level of the selected reference |

## Verification
The hardest situation to reach is the return to a preferred input. This needs the preferred input to go silent for longer than the loss limit while a lower slot stays qualified, and then to run clean for a full qualification run again. The bench gets there with per-input period generators that it can stop and restart at any time. The bench instantiates the block with a shortened nominal period so that each requalification fits into a few thousand cycles. Off-window periods, a disabled but healthy input, an invalid slot entry and the release of free-running are layered onto the same run. A behavioural model built from queues and integers is compared with the outputs on every clock.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    typedef enum logic [1:0] {
        MON_LOST  = 2'd0,
        MON_QUAL  = 2'd1,
        MON_GOOD  = 2'd2
    } mon_state_t;

    typedef enum logic [1:0] {
        SEL_FREE   = 2'd0,
        SEL_SEARCH = 2'd1,
        SEL_TRACK  = 2'd2
    } sel_state_t;

endpackage

// File: rtl/tsel_ref_monitor.sv
module tsel_ref_monitor
    import tsel_pkg::*;
#(
    parameter int NOM_PERIOD   = 2048,
    parameter int TOL_CYCLES   = 20,
    parameter int LOSS_LIMIT   = 4096,
    parameter int QUAL_PERIODS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_async,
    output logic healthy,
    output logic ref_lvl
);
    localparam int CW    = $clog2(LOSS_LIMIT + 1);
    localparam int QW    = $clog2(QUAL_PERIODS + 1);
    localparam int WIN_L = NOM_PERIOD - TOL_CYCLES;
    localparam int WIN_H = NOM_PERIOD + TOL_CYCLES;

    logic        sync1_q, sync2_q, sync3_q;
    logic        edge_seen;
    logic [CW-1:0] cnt_q;
    logic [QW-1:0] run_q, run_d;
    mon_state_t  state_q, state_d;
    logic        in_win, timeout;

    // two-flop synchronizer plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            sync3_q <= 1'b0;
        end else begin
            sync1_q <= ref_async;
            sync2_q <= sync1_q;
            sync3_q <= sync2_q;
        end
    end

    assign edge_seen = sync2_q & ~sync3_q;
    assign ref_lvl   = sync2_q;

    // cycles since the last edge, saturating at the loss limit
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (edge_seen) begin
            cnt_q <= CW'(1);
        end else if (cnt_q < CW'(LOSS_LIMIT)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign in_win  = (cnt_q >= CW'(WIN_L)) && (cnt_q <= CW'(WIN_H));
    assign timeout = !edge_seen && (cnt_q >= CW'(LOSS_LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MON_LOST;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            MON_LOST: begin
                if (edge_seen) begin
                    state_d = MON_QUAL;
                    run_d   = '0;
                end
            end
            MON_QUAL: begin
                if (edge_seen) begin
                    if (!in_win) begin
                        run_d = '0;
                    end else if (run_q == QW'(QUAL_PERIODS - 1)) begin
                        state_d = MON_GOOD;
                        run_d   = '0;
                    end else begin
                        run_d = run_q + QW'(1);
                    end
                end else if (timeout) begin
                    state_d = MON_LOST;
                    run_d   = '0;
                end
            end
            MON_GOOD: begin
                if (timeout) begin
                    state_d = MON_LOST;
                end
            end
            default: begin
                state_d = MON_LOST;
                run_d   = '0;
            end
        endcase
    end

    assign healthy = (state_q == MON_GOOD);

    // R2: qualification completes only on an edge
    assert_qual_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(healthy) |-> $past(edge_seen));

    // R4: health is only lost after a full silent window
    assert_loss_after_limit_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(healthy) |-> $past(cnt_q) == CW'(LOSS_LIMIT));

endmodule

// File: rtl/tsel_prio_pick.sv
module tsel_prio_pick #(
    parameter int N_REF = 7,
    parameter int IDX_W = 3
) (
    input  logic [N_REF-1:0]       healthy,
    input  logic [N_REF-1:0]       enable,
    input  logic [N_REF*IDX_W-1:0] slots,
    output logic                   found,
    output logic [IDX_W-1:0]       cand
);
    localparam int PAD = 1 << IDX_W;

    logic [PAD-1:0] usable;

    // padded so that any slot entry indexes a defined bit; entries >= N_REF read 0
    assign usable = PAD'(healthy & enable);

    always_comb begin
        found = 1'b0;
        cand  = '0;
        for (int s = N_REF - 1; s >= 0; s--) begin
            if (usable[slots[s*IDX_W +: IDX_W]]) begin
                found = 1'b1;
                cand  = slots[s*IDX_W +: IDX_W];
            end
        end
    end

endmodule

// File: rtl/tsel_ref_selector.sv
module tsel_ref_selector
    import tsel_pkg::*;
#(
    parameter int N_REF        = 7,
    parameter int NOM_PERIOD   = 2048,
    parameter int TOL_CYCLES   = NOM_PERIOD / 100,
    parameter int LOSS_LIMIT   = 2 * NOM_PERIOD,
    parameter int QUAL_PERIODS = 16,
    localparam int IDX_W       = (N_REF > 1) ? $clog2(N_REF) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_REF-1:0]       ref_in,
    input  logic [N_REF-1:0]       ref_en,
    input  logic [N_REF*IDX_W-1:0] prio_slots,
    input  logic                   free_run,
    output logic [IDX_W-1:0]       ref_sel,
    output logic                   ref_valid,
    output logic                   switch_event,
    output logic                   ref_out
);
    logic [N_REF-1:0] healthy_vec;
    logic [N_REF-1:0] lvl_vec;
    logic             found;
    logic [IDX_W-1:0] cand;

    sel_state_t       state_q, state_d;
    logic [IDX_W-1:0] sel_q, sel_d;
    logic             sw_q, sw_d;

    for (genvar g = 0; g < N_REF; g++) begin : g_mon
        tsel_ref_monitor #(
            .NOM_PERIOD  (NOM_PERIOD),
            .TOL_CYCLES  (TOL_CYCLES),
            .LOSS_LIMIT  (LOSS_LIMIT),
            .QUAL_PERIODS(QUAL_PERIODS)
        ) i_mon (
            .clk      (clk),
            .rst      (rst),
            .ref_async(ref_in[g]),
            .healthy  (healthy_vec[g]),
            .ref_lvl  (lvl_vec[g])
        );
    end

    tsel_prio_pick #(
        .N_REF(N_REF),
        .IDX_W(IDX_W)
    ) i_pick (
        .healthy(healthy_vec),
        .enable (ref_en),
        .slots  (prio_slots),
        .found  (found),
        .cand   (cand)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEL_FREE;
            sel_q   <= '0;
            sw_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            sw_q    <= sw_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        sw_d    = 1'b0;
        unique case (state_q)
            SEL_FREE, SEL_SEARCH: begin
                if (free_run) begin
                    state_d = SEL_FREE;
                    sel_d   = '0;
                end else if (found) begin
                    state_d = SEL_TRACK;
                    sel_d   = cand;
                    sw_d    = 1'b1;
                end else begin
                    state_d = SEL_SEARCH;
                    sel_d   = '0;
                end
            end
            SEL_TRACK: begin
                if (free_run) begin
                    state_d = SEL_FREE;
                    sel_d   = '0;
                end else if (found) begin
                    sel_d = cand;
                    sw_d  = (cand != sel_q);
                end else begin
                    state_d = SEL_SEARCH;
                    sel_d   = '0;
                end
            end
            default: begin
                state_d = SEL_SEARCH;
                sel_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        ref_valid    = (state_q == SEL_TRACK);
        ref_sel      = sel_q;
        switch_event = sw_q;
        ref_out      = ref_valid & lvl_vec[sel_q];
    end

    // R5: a valid selection names an input that was healthy one cycle earlier
    assert_sel_healthy_R5: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> (($past(healthy_vec) >> ref_sel) & N_REF'(1)) != '0);

    // R8: free-running drops the reference on the next cycle
    assert_free_run_R8: assert property (@(posedge clk) disable iff (rst)
        $past(free_run) |-> !ref_valid);

    // R10: a switch pulse always comes with a valid selection
    assert_switch_valid_R10: assert property (@(posedge clk) disable iff (rst)
        switch_event |-> ref_valid);

    // R9: with no selection the index and clock outputs rest at zero
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !ref_valid |-> (ref_sel == '0) && !ref_out);

endmodule

// File: tb/test_tsel_ref_selector.sv
module test_tsel_ref_selector;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 7;
    localparam int IW   = 3;
    localparam int NOM  = 200;
    localparam int TOL  = NOM / 100;
    localparam int LOSS = 2 * NOM;
    localparam int QUAL = 16;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] refv = '0;
    logic [N-1:0] en = '0;
    logic [N*IW-1:0] slots;
    logic free_run = 1'b0;
    logic [IW-1:0] ref_sel;
    logic ref_valid, switch_event, ref_out;

    int prio [N];
    int per [N];
    int ph [N];
    int vectors = 0;
    int errors = 0;
    int sw_cnt = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int s = 0; s < N; s++) slots[s*IW +: IW] = IW'(prio[s]);
    end

    tsel_ref_selector #(.N_REF(N), .NOM_PERIOD(NOM)) i_tsel_ref_selector (
        .clk(clk), .rst(rst), .ref_in(refv), .ref_en(en), .prio_slots(slots),
        .free_run(free_run), .ref_sel(ref_sel), .ref_valid(ref_valid),
        .switch_event(switch_event), .ref_out(ref_out)
    );

    // reference generators: period 0 holds the line low
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (per[i] == 0) begin
                ph[i] = 0;
                refv[i] = 1'b0;
            end else begin
                refv[i] = (ph[i] < per[i] / 2);
                ph[i] = (ph[i] + 1) % per[i];
            end
        end
    end

    // behavioural reference model
    int  m_state [N];
    int  m_since [N];
    int  m_run [N];
    bit  m_ok [N];
    int  m_sel;
    bit  m_val, m_sw, m_out;
    logic [N-1:0] hist [$];

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_state[i] = 0; m_since[i] = 0; m_run[i] = 0; m_ok[i] = 0;
            end
            hist = {};
            for (int k = 0; k < 3; k++) hist.push_back('0);
            m_sel = 0; m_val = 0; m_sw = 0; m_out = 0;
        end else begin
            int pick;
            pick = -1;
            for (int s = N - 1; s >= 0; s--)
                if (prio[s] < N && en[prio[s]] && m_ok[prio[s]]) pick = prio[s];
            if (free_run || pick < 0) begin
                m_val = 0; m_sel = 0; m_sw = 0;
            end else begin
                m_sw = !m_val || (pick != m_sel);
                m_val = 1; m_sel = pick;
            end
            for (int i = 0; i < N; i++) begin
                bit rise;
                bit quiet;
                rise = hist[1][i] && !hist[2][i];
                quiet = !rise && (m_since[i] >= LOSS);
                case (m_state[i])
                    0: if (rise) begin m_state[i] = 1; m_run[i] = 0; end
                    1: begin
                        if (rise) begin
                            if (m_since[i] < NOM - TOL || m_since[i] > NOM + TOL) m_run[i] = 0;
                            else if (m_run[i] + 1 == QUAL) begin m_state[i] = 2; m_run[i] = 0; end
                            else m_run[i]++;
                        end else if (quiet) begin
                            m_state[i] = 0; m_run[i] = 0;
                        end
                    end
                    default: if (quiet) m_state[i] = 0;
                endcase
                if (rise) m_since[i] = 1;
                else if (m_since[i] < LOSS) m_since[i]++;
                m_ok[i] = (m_state[i] == 2);
            end
            m_out = m_val ? hist[0][m_sel] : 1'b0;
            hist.push_front(refv);
            void'(hist.pop_back());
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (!rst && !done) begin
            vectors++;
            if (ref_valid !== m_val || ref_sel !== IW'(m_sel)) begin
                errors++;
                $display("FAIL R5 R12 cycle %0d: valid/sel %0b/%0d expected %0b/%0d",
                         cyc, ref_valid, ref_sel, m_val, m_sel);
            end
            if (switch_event !== m_sw) begin
                errors++;
                $display("FAIL R10 cycle %0d: switch_event %0b expected %0b", cyc, switch_event, m_sw);
            end
            if (ref_out !== m_out) begin
                errors++;
                $display("FAIL R11 cycle %0d: ref_out %0b expected %0b", cyc, ref_out, m_out);
            end
            if (switch_event) sw_cnt++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin per[i] = 0; ph[i] = 0; end
        prio[0] = 2; prio[1] = 7; prio[2] = 0; prio[3] = 1;
        prio[4] = 3; prio[5] = 4; prio[6] = 5;
        en = 7'b0001111;
        wait_cyc(8);
        // R1: reset values
        chk("R1 valid", ref_valid, 0);
        chk("R1 sel", ref_sel, 0);
        chk("R1 switch", switch_event, 0);
        chk("R1 ref_out", ref_out, 0);
        rst = 1'b0;
        per[0] = NOM; per[1] = NOM; per[2] = NOM;
        per[3] = NOM + 30;           // outside the window (R3)
        per[4] = NOM;                // healthy but disabled (R7)
        wait_cyc(NOM * (QUAL + 1) - 200);
        chk("R2 not yet qualified", ref_valid, 0);
        wait_cyc(400);
        chk("R2 qualified", ref_valid, 1);
        chk("R5 top slot wins", ref_sel, 2);
        // R4 and R6: failover after loss
        per[2] = 0;
        wait_cyc(LOSS + NOM + 100);
        chk("R4 R6 fallback", ref_sel, 0);
        chk("R6 still valid", ref_valid, 1);
        per[2] = NOM;
        wait_cyc(NOM * (QUAL + 1) + 300);
        chk("R6 revert", ref_sel, 2);
        // R3 R7 R9: only an off-window input and a disabled one remain
        per[0] = 0; per[1] = 0; per[2] = 0;
        wait_cyc(LOSS + NOM + 100);
        chk("R3 R7 R9 no candidate", ref_valid, 0);
        chk("R9 sel zero", ref_sel, 0);
        chk("R9 out zero", ref_out, 0);
        en[4] = 1'b1;
        wait_cyc(3);
        chk("R7 enabled input taken", ref_sel, 4);
        chk("R7 valid", ref_valid, 1);
        // R8 and R10
        free_run = 1'b1;
        wait_cyc(4);
        chk("R8 free run", ref_valid, 0);
        sw_cnt = 0;
        free_run = 1'b0;
        wait_cyc(6);
        chk("R10 one pulse on release", sw_cnt, 1);
        chk("R10 reselected", ref_sel, 4);
        // R11: the passed-through clock toggles at the reference rate
        begin
            int rises;
            logic prev;
            rises = 0;
            prev = ref_out;
            for (int k = 0; k < 10 * NOM; k++) begin
                @(negedge clk);
                if (ref_out && !prev) rises++;
                prev = ref_out;
            end
            chk("R11 ref_out edges", (rises >= 9 && rises <= 11) ? 1 : 0, 1);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        done = 1'b1;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule